// File: doc/BRIEF.md
# Packet Buffer Port Controller

This controller owns one port of a dual-port line RAM and uses it to carry exactly one packet for each command it receives. A control word comes in with a single-cycle `go` strobe. That word picks the operation, a start line, an end line and an address stride. In write mode the controller takes words from a producer stream and stores them along the programmed line range. In read mode it streams the range back out to a consumer and flags the start and end of the packet. A range whose end line is numerically lower than its start line wraps through the top of the RAM to line 0.

The consumer and the producer can each end a packet early with a done input, or abort it with an error input. The controller reports done, error and idle status bits. These stay put until the next command.

The state machine has five states. ST_IDLE means nothing is in progress. ST_RD_FETCH issues the prefetch read of the first line. ST_RD_SHOW presents the current line on the read stream. ST_WR_RUN accepts producer words. ST_WR_FULL means the range has been completely written.

The transitions are as follows:
- go with a read command moves to ST_RD_FETCH.
- go with a write command moves to ST_WR_RUN.
- go with any other command moves to ST_IDLE.
- ST_RD_FETCH always moves to ST_RD_SHOW.
- ST_RD_SHOW returns to ST_IDLE on error, on done, or on a read pulse at the end line.
- ST_WR_RUN returns to ST_IDLE on error or done.
- ST_WR_RUN moves to ST_WR_FULL when the end line is written.
- ST_WR_FULL holds until the next go.

Top module: `pktbuf_port_ctrl`

## Requirements
- R1: The control word is decoded only in a cycle where `go` is high. With A = ADDR_W, the fields are: start line in bits [A-1:0], end line in bits [2A-1:A], stride in bits [2A+3:2A], read in bit 2A+4, write in bit 2A+5 and clear in bit 2A+6. For A = 9 these are bits 8:0, 17:9, 21:18, 22, 23 and 24. While `go` is low, the word has no effect.
- R2: After a read command the controller prefetches the start line. Two cycles after `go`, `rd_data` holds that line and `rd_sop` is high, before any read pulse. With no read pulse, the data and the marks stay steady.
- R3: Each read pulse moves the read stream to the next line of the range. `rd_eop` is high while the end line is shown. A read pulse on the end line finishes the packet, which sets done and idle.
- R4: When the end line is below the start line, both reading and writing visit the start line up to the top line, then line 0 up to the end line.
- R5: Read pulses after the packet has finished are ignored. They cause no RAM access and no start or end mark, and done stays high.
- R6: In write mode `wr_ready` is high, and each write pulse stores `wr_data` into the current line of the range. Writing the end line raises `wr_full` and done, and lowers `wr_ready`.
- R7: Write pulses after `wr_full` are dropped. No RAM access takes place, and no RAM line outside the range ever changes.
- R8: A done input from the active stream ends the packet early and sets done. A write pulse in the same cycle is still stored. A read pulse in the same cycle is consumed.
- R9: An error input from the active stream aborts the packet. It sets error, clears done, and stops the write of that cycle's word. Error takes priority over a simultaneous done.
- R10: A command with the clear bit set returns the controller to idle from any state with done and error both low. Clear takes priority over read and write. Any new command also clears the previous done and error.
- R11: A command with both read and write set is illegal. It leaves the controller idle with error set and makes no RAM access.
- R12: The address advances by the stride field for each transfer, modulo the RAM depth. A stride of 0 acts as 1.
- R13: `stat_idle` is low exactly while a prefetch, a read packet or a write packet is in progress. Done and error are never high together. After reset the controller is idle with every stream and RAM output low.
- R14: Control word bits above the clear bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | One-cycle command strobe |
| ctrl_word | input | CTRL_W | Command: range, stride, operation |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | ADDR_W | RAM port line address |
| ram_wdata | output | DATA_W | Data written into the RAM |
| ram_rdata | input | DATA_W | Data read from the RAM, one cycle after an enabled read, held otherwise |
| wr_data | input | DATA_W | Producer word |
| wr_write | input | 1 | Producer write pulse |
| wr_done | input | 1 | Producer ends packet early |
| wr_error | input | 1 | Producer aborts packet |
| wr_ready | output | 1 | Write packet accepting words |
| wr_full | output | 1 | Whole range written |
| rd_data | output | DATA_W | Current line for the consumer |
| rd_read | input | 1 | Consumer read pulse, advances one line |
| rd_done | input | 1 | Consumer ends packet early |
| rd_error | input | 1 | Consumer aborts packet |
| rd_sop | output | 1 | Current line is the first of the packet |
| rd_eop | output | 1 | Current line is the end line |
| stat_done | output | 1 | Last packet finished normally |
| stat_error | output | 1 | Last packet aborted or command illegal |
| stat_idle | output | 1 | No transfer in progress |

## Verification
The bench builds the controller with ADDR_W = 5, which gives a 32-line RAM, and keeps DATA_W = 32 and CTRL_W = 32. The fields therefore sit at bits 4:0, 9:5, 13:10, 14, 15 and 16. Bits 31:17 carry random junk. With only 32 lines, wrapping ranges, a range that covers the whole RAM and a full comparison of the RAM image after every write packet all fit in short runs. Random packets with random gaps between pulses run alongside directed early-done, error, clear, illegal-command and stride cases.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FETCH,
        ST_RD_SHOW,
        ST_WR_RUN,
        ST_WR_FULL
    } pb_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLEAR,
        OP_READ,
        OP_WRITE,
        OP_BAD
    } pb_op_t;

endpackage

// File: rtl/pktbuf_cmd_decode.sv
module pktbuf_cmd_decode
    import pktbuf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CTRL_W = 32
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic [ADDR_W-1:0] first_line,
    output logic [ADDR_W-1:0] end_line,
    output logic [3:0]        stride,
    output pb_op_t            op
);
    localparam int STRIDE_LSB = 2 * ADDR_W;
    localparam int RD_BIT     = STRIDE_LSB + 4;
    localparam int WR_BIT     = RD_BIT + 1;
    localparam int CLR_BIT    = WR_BIT + 1;

    logic do_rd, do_wr, do_clr;

    assign first_line = ctrl[ADDR_W-1:0];
    assign end_line   = ctrl[2*ADDR_W-1:ADDR_W];
    assign stride     = ctrl[STRIDE_LSB+3:STRIDE_LSB];
    assign do_rd      = ctrl[RD_BIT];
    assign do_wr      = ctrl[WR_BIT];
    assign do_clr     = ctrl[CLR_BIT];

    // R14: upper bits carry routing tags that this block does not use
    generate
        if (CTRL_W > CLR_BIT + 1) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^ctrl[CTRL_W-1:CLR_BIT+1];
        end
    endgenerate

    // R10: clear outranks everything; R11: both directions is illegal
    always_comb begin
        if (do_clr)               op = OP_CLEAR;
        else if (do_rd && do_wr)  op = OP_BAD;
        else if (do_rd)           op = OP_READ;
        else if (do_wr)           op = OP_WRITE;
        else                      op = OP_NONE;
    end

endmodule

// File: rtl/pktbuf_line_walker.sv
module pktbuf_line_walker #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] first_line,
    input  logic [ADDR_W-1:0] end_line,
    input  logic [3:0]        stride,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt,
    output logic              at_first,
    output logic              at_end
);
    logic [ADDR_W-1:0] end_q;
    logic [3:0]        stride_q;
    logic              fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            end_q    <= '0;
            stride_q <= 4'd1;
            fresh_q  <= 1'b0;
        end else if (load) begin
            cur      <= first_line;
            end_q    <= end_line;
            stride_q <= (stride == 4'd0) ? 4'd1 : stride;   // R12
            fresh_q  <= 1'b1;
        end else if (adv) begin
            cur      <= nxt;
            fresh_q  <= 1'b0;
        end
    end

    // R4: natural wrap of the ADDR_W-bit sum walks through line 0
    assign nxt      = cur + ADDR_W'(stride_q);
    assign at_first = fresh_q;
    assign at_end   = (cur == end_q);

    // R3: once the stream has moved, the start mark is gone
    p_first_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> !at_first);

endmodule

// File: rtl/pktbuf_port_ctrl.sv
module pktbuf_port_ctrl
    import pktbuf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_write,
    input  logic              wr_done,
    input  logic              wr_error,
    output logic              wr_ready,
    output logic              wr_full,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_read,
    input  logic              rd_done,
    input  logic              rd_error,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              stat_done,
    output logic              stat_error,
    output logic              stat_idle
);
    pb_state_t         state_q, state_d;
    pb_op_t            cmd_op;
    logic [ADDR_W-1:0] cmd_first, cmd_end, cur, nxt;
    logic [3:0]        cmd_stride;
    logic              at_first, at_end;
    logic              walk_load, rd_adv, wr_store, walk_adv;
    logic              done_q, err_q;

    pktbuf_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_decode (
        .ctrl       (ctrl_word),
        .first_line (cmd_first),
        .end_line   (cmd_end),
        .stride     (cmd_stride),
        .op         (cmd_op)
    );

    assign walk_load = go && (cmd_op == OP_READ || cmd_op == OP_WRITE);
    assign rd_adv    = !go && (state_q == ST_RD_SHOW) && rd_read && !at_end
                       && !rd_done && !rd_error;
    assign wr_store  = !go && (state_q == ST_WR_RUN) && wr_write && !wr_error;
    assign walk_adv  = rd_adv || (wr_store && !at_end);

    pktbuf_line_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (walk_load),
        .first_line (cmd_first),
        .end_line   (cmd_end),
        .stride     (cmd_stride),
        .adv        (walk_adv),
        .cur        (cur),
        .nxt        (nxt),
        .at_first   (at_first),
        .at_end     (at_end)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state (R1: a command acts only with go)
    always_comb begin
        state_d = state_q;
        if (go) begin
            unique case (cmd_op)
                OP_READ:  state_d = ST_RD_FETCH;
                OP_WRITE: state_d = ST_WR_RUN;
                default:  state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_RD_FETCH: state_d = ST_RD_SHOW;
                ST_RD_SHOW: begin
                    if (rd_error || rd_done)     state_d = ST_IDLE;
                    else if (rd_read && at_end)  state_d = ST_IDLE;
                end
                ST_WR_RUN: begin
                    if (wr_error)                state_d = ST_IDLE;
                    else if (wr_write && at_end) state_d = ST_WR_FULL;
                    else if (wr_done)            state_d = ST_IDLE;
                end
                ST_WR_FULL:  state_d = ST_WR_FULL;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Sticky status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (go) begin
            done_q <= 1'b0;
            err_q  <= (cmd_op == OP_BAD);
        end else if (state_q == ST_RD_SHOW) begin
            if (rd_error)                          err_q  <= 1'b1;
            else if (rd_done || (rd_read && at_end)) done_q <= 1'b1;
        end else if (state_q == ST_WR_RUN) begin
            if (wr_error)                            err_q  <= 1'b1;
            else if (wr_done || (wr_write && at_end)) done_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ram_en     = (state_q == ST_RD_FETCH && !go) || rd_adv || wr_store;
        ram_we     = wr_store;
        ram_addr   = rd_adv ? nxt : cur;
        ram_wdata  = wr_data;
        rd_data    = ram_rdata;
        rd_sop     = (state_q == ST_RD_SHOW) && at_first;
        rd_eop     = (state_q == ST_RD_SHOW) && at_end;
        wr_ready   = (state_q == ST_WR_RUN);
        wr_full    = (state_q == ST_WR_FULL);
        stat_done  = done_q;
        stat_error = err_q;
        stat_idle  = !(state_q == ST_RD_FETCH || state_q == ST_RD_SHOW
                       || state_q == ST_WR_RUN);
    end

    p_we_in_wr_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (wr_ready && ram_en));

    p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_full && !go) |=> (wr_full && !ram_en));

    p_hold_show_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD_SHOW && !go && !rd_read && !rd_done && !rd_error)
        |=> ($stable(rd_data) && rd_sop == $past(rd_sop) && !stat_idle));

    p_bad_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        (go && cmd_op == OP_BAD) |=> (stat_error && stat_idle && !ram_en));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (go && cmd_op == OP_CLEAR) |=> (stat_idle && !stat_done && !stat_error));

    p_status_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(stat_done && stat_error));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (!go && state_q == ST_RD_SHOW && rd_error) |=> (stat_error && stat_idle));

endmodule

// File: tb/pktbuf_port_ctrl_tb.sv
module pktbuf_port_ctrl_tb;
    localparam int A      = 5;
    localparam int LINES  = 1 << A;
    localparam int DW     = 32;
    localparam int CW     = 32;
    localparam int SLSB   = 2 * A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0;
    logic [CW-1:0] ctrl_word = '0;
    logic          ram_en, ram_we;
    logic [A-1:0]  ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_write = 1'b0, wr_done = 1'b0, wr_error = 1'b0;
    logic          wr_ready, wr_full;
    logic [DW-1:0] rd_data;
    logic          rd_read = 1'b0, rd_done = 1'b0, rd_error = 1'b0;
    logic          rd_sop, rd_eop, stat_done, stat_error, stat_idle;

    logic [DW-1:0] mem   [LINES];
    logic [DW-1:0] model [LINES];
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pktbuf_port_ctrl #(.ADDR_W(A), .DATA_W(DW), .CTRL_W(CW)) u_dut (
        .clk(clk), .rst(rst), .go(go), .ctrl_word(ctrl_word),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .wr_data(wr_data), .wr_write(wr_write), .wr_done(wr_done),
        .wr_error(wr_error), .wr_ready(wr_ready), .wr_full(wr_full),
        .rd_data(rd_data), .rd_read(rd_read), .rd_done(rd_done),
        .rd_error(rd_error), .rd_sop(rd_sop), .rd_eop(rd_eop),
        .stat_done(stat_done), .stat_error(stat_error), .stat_idle(stat_idle)
    );

    // RAM model: synchronous, output held when not enabled
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata     <= mem[ram_addr];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] mk(input int first, input int last,
            input int stride, input bit rd, input bit wr, input bit clr);
        logic [CW-1:0] w;
        w = $urandom;                       // R14: junk in the upper bits
        w[A-1:0]         = first[A-1:0];
        w[2*A-1:A]       = last[A-1:0];
        w[SLSB+3:SLSB]   = stride[3:0];
        w[SLSB+4]        = rd;
        w[SLSB+5]        = wr;
        w[SLSB+6]        = clr;
        return w;
    endfunction

    function automatic int step_of(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    function automatic int ram_mismatches();
        int n = 0;
        for (int i = 0; i < LINES; i++) if (mem[i] !== model[i]) n++;
        return n;
    endfunction

    task automatic send(input logic [CW-1:0] w);
        @(negedge clk);
        go = 1'b1; ctrl_word = w;
        @(negedge clk);
        go = 1'b0; ctrl_word = $urandom;    // R1: ignored without go
    endtask

    task automatic rd_pulse(input bit r, input bit d, input bit e);
        rd_read = r; rd_done = d; rd_error = e;
        @(negedge clk);
        rd_read = 1'b0; rd_done = 1'b0; rd_error = 1'b0;
    endtask

    task automatic wr_pulse(input bit w, input bit d, input bit e,
                            input logic [DW-1:0] v);
        wr_write = w; wr_done = d; wr_error = e; wr_data = v;
        @(negedge clk);
        wr_write = 1'b0; wr_done = 1'b0; wr_error = 1'b0;
    endtask

    task automatic expect_line(input string req, input int line,
                               input bit sop, input bit eop);
        chk(req, "rd_data", rd_data, model[line]);
        chk(req, "rd_sop", rd_sop, sop);
        chk(req, "rd_eop", rd_eop, eop);
        chk("R13", "idle during read", stat_idle, 1'b0);
    endtask

    // Full read packet; assumes send() of the read command just returned
    task automatic read_pkt(input string req, input int first, input int last,
                            input int stride, input int wmax);
        int line = first;
        @(negedge clk);                      // prefetch cycle
        for (int idx = 0; idx < 64; idx++) begin
            expect_line(req, line, idx == 0, line == last);
            if (wmax > 0) begin
                repeat ($urandom_range(wmax, 0)) @(negedge clk);
                expect_line("R2", line, idx == 0, line == last);
            end
            rd_pulse(1, 0, 0);
            if (line == last) break;
            line = (line + step_of(stride)) % LINES;
        end
        chk(req, "done after read", stat_done, 1'b1);
        chk(req, "idle after read", stat_idle, 1'b1);
        chk(req, "error after read", stat_error, 1'b0);
    endtask

    // Full write packet; assumes send() of the write command just returned
    task automatic write_pkt(input string req, input int first, input int last,
                             input int stride, input int wmax);
        int line = first;
        for (int idx = 0; idx < 64; idx++) begin
            logic [DW-1:0] v;
            v = $urandom;
            chk(req, "wr_ready", wr_ready, 1'b1);
            chk(req, "wr_full early", wr_full, 1'b0);
            wr_write = 1'b1; wr_data = v;
            #1;
            chk(req, "ram_we", ram_we, 1'b1);
            chk(req, "ram_addr", ram_addr, line[A-1:0]);
            @(negedge clk);
            wr_write = 1'b0;
            model[line] = v;
            if (line == last) break;
            if (wmax > 0) repeat ($urandom_range(wmax, 0)) @(negedge clk);
            line = (line + step_of(stride)) % LINES;
        end
        chk("R6", "wr_full", wr_full, 1'b1);
        chk("R6", "wr_ready after full", wr_ready, 1'b0);
        chk("R6", "done after write", stat_done, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL all: watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed_tap;
        seed_tap = $urandom(32'd4242);
        for (int i = 0; i < LINES; i++) begin
            mem[i] = $urandom;
            model[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        chk("R13", "idle at reset", stat_idle, 1'b1);
        chk("R13", "done at reset", stat_done, 1'b0);
        chk("R13", "error at reset", stat_error, 1'b0);
        chk("R13", "ready/full/sop/eop at reset",
            {wr_ready, wr_full, rd_sop, rd_eop, ram_en}, '0);

        // R1 command without go has no effect
        ctrl_word = mk(3, 7, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1", "no go -> idle", stat_idle, 1'b1);
        chk("R1", "no go -> no ram access", ram_en, 1'b0);

        // R2 R3 R14 plain read
        send(mk(3, 9, 1, 1, 0, 0));
        read_pkt("R3", 3, 9, 1, 0);

        // R5 reads after finish ignored
        for (int k = 0; k < 3; k++) begin
            rd_read = 1'b1;
            #1;
            chk("R5", "ram_en after finish", ram_en, 1'b0);
            @(negedge clk);
            rd_read = 1'b0;
            chk("R5", "marks after finish", {rd_sop, rd_eop}, 2'b00);
            chk("R5", "done held", stat_done, 1'b1);
        end

        // R4 wrapping read with gaps
        send(mk(28, 3, 1, 1, 0, 0));
        read_pkt("R4", 28, 3, 1, 2);

        // R6 R7 write, then excess writes, then RAM image
        send(mk(10, 15, 1, 0, 1, 0));
        write_pkt("R6", 10, 15, 1, 1);
        for (int k = 0; k < 3; k++) begin
            wr_write = 1'b1; wr_data = $urandom;
            #1;
            chk("R7", "ram_en after full", ram_en, 1'b0);
            @(negedge clk);
            wr_write = 1'b0;
            chk("R7", "full held", wr_full, 1'b1);
        end
        chk("R7", "ram image", ram_mismatches(), 0);

        // R4 wrapping write and readback
        send(mk(30, 2, 1, 0, 1, 0));
        write_pkt("R4", 30, 2, 1, 0);
        chk("R4", "ram image wrap write", ram_mismatches(), 0);
        send(mk(29, 3, 1, 1, 0, 0));
        read_pkt("R4", 29, 3, 1, 0);

        // R4 whole RAM range
        send(mk(7, 6, 1, 0, 1, 0));
        write_pkt("R4", 7, 6, 1, 0);
        send(mk(7, 6, 1, 1, 0, 0));
        read_pkt("R4", 7, 6, 1, 0);

        // R8 early done on read, alone and with a read pulse
        send(mk(0, 10, 1, 1, 0, 0));
        @(negedge clk);
        rd_pulse(1, 0, 0);
        rd_pulse(1, 0, 0);
        expect_line("R8", 2, 0, 0);
        rd_pulse(0, 1, 0);
        chk("R8", "done after rd_done", stat_done, 1'b1);
        chk("R8", "idle after rd_done", stat_idle, 1'b1);
        send(mk(0, 10, 1, 1, 0, 0));
        chk("R10", "new command clears done", stat_done, 1'b0);
        @(negedge clk);
        rd_pulse(1, 1, 0);
        chk("R8", "done with read", stat_done, 1'b1);
        chk("R8", "eop gone", rd_eop, 1'b0);

        // R8 early done on write with a simultaneous word
        send(mk(20, 27, 1, 0, 1, 0));
        for (int k = 0; k < 3; k++) begin
            logic [DW-1:0] v;
            v = $urandom;
            model[20 + k] = v;
            wr_pulse(1, 0, 0, v);
        end
        begin
            logic [DW-1:0] v;
            v = $urandom;
            model[23] = v;
            wr_pulse(1, 1, 0, v);
        end
        chk("R8", "write done", stat_done, 1'b1);
        chk("R8", "not full", wr_full, 1'b0);
        chk("R8", "ram image after done", ram_mismatches(), 0);

        // R9 read abort, and error with done
        send(mk(4, 12, 1, 1, 0, 0));
        @(negedge clk);
        rd_pulse(1, 0, 0);
        rd_pulse(1, 0, 1);
        chk("R9", "error on read abort", stat_error, 1'b1);
        chk("R9", "no done on read abort", stat_done, 1'b0);
        send(mk(4, 12, 1, 1, 0, 0));
        @(negedge clk);
        rd_pulse(1, 1, 1);
        chk("R9", "error wins over done", {stat_error, stat_done}, 2'b10);

        // R9 write abort drops the word
        send(mk(16, 19, 1, 0, 1, 0));
        begin
            logic [DW-1:0] v;
            v = $urandom;
            model[16] = v;
            wr_pulse(1, 0, 0, v);
            wr_pulse(1, 0, 1, ~v);
        end
        chk("R9", "error on write abort", stat_error, 1'b1);
        chk("R9", "ram image after abort", ram_mismatches(), 0);

        // R10 clear from error, clear mid-read, clear with read bit
        send(mk(0, 0, 0, 0, 0, 1));
        chk("R10", "clear flags", {stat_done, stat_error, stat_idle}, 3'b001);
        send(mk(0, 20, 1, 1, 0, 0));
        @(negedge clk);
        rd_pulse(1, 0, 0);
        send(mk(0, 20, 1, 0, 0, 1));
        chk("R10", "clear mid-read", {stat_idle, rd_sop, rd_eop, stat_done}, 4'b1000);
        send(mk(0, 20, 1, 1, 1, 1));
        @(negedge clk);
        chk("R10", "clear outranks read", {stat_idle, ram_en, stat_error}, 3'b100);

        // R11 illegal command
        send(mk(1, 5, 1, 1, 1, 0));
        chk("R11", "illegal -> error", stat_error, 1'b1);
        chk("R11", "illegal -> idle", stat_idle, 1'b1);
        chk("R11", "illegal -> no ram", ram_en, 1'b0);

        // R12 stride 2 and stride 0
        send(mk(2, 8, 2, 1, 0, 0));
        read_pkt("R12", 2, 8, 2, 0);
        send(mk(4, 6, 0, 1, 0, 0));
        read_pkt("R12", 4, 6, 0, 0);

        // Random packets
        for (int it = 0; it < 40; it++) begin
            int f, l;
            f = $urandom_range(LINES - 1, 0);
            l = $urandom_range(LINES - 1, 0);
            if ($urandom_range(1, 0) == 1) begin
                send(mk(f, l, 1, 0, 1, 0));
                write_pkt("R6", f, l, 1, 2);
                chk("R7", "ram image random", ram_mismatches(), 0);
            end else begin
                send(mk(f, l, 1, 1, 0, 0));
                read_pkt("R3", f, l, 1, 2);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule